// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This unit sits beside the integer pipeline of a 32-bit processor core. It runs long multiply and divide operations and keeps their results in two architectural result registers, HI and LO. An operation is handed over with a one-cycle `start` pulse that carries a 3-bit operation code and two operands. The unit then works through the operation one bit per cycle on a shift-add multiplier or a restoring divider, and holds `busy` high until it commits the result. Signed operations are run on magnitudes, and the signs are applied in a final fix-up cycle.

A multiply leaves the upper half of its double-width product in HI and the lower half in LO. A divide leaves the remainder in HI and the quotient in LO. A divide never traps. Division by zero and the one signed overflow case (most-negative value over minus one) commit fixed values. Two move operations load HI or LO directly in a single cycle. HI and LO can be read at the outputs at all times. Stalling a consumer that reads them while `busy` is high is the job of the surrounding pipeline.

Top module: `muldiv_hilo`

## Requirements
- R1: After a synchronous reset, including a reset in the middle of an operation, HI and LO read zero and `busy` is low.
- R2: Code 0 (signed multiply) commits the 64-bit product of the sign-extended operands, with bits 63:32 in HI and bits 31:0 in LO.
- R3: Code 1 (unsigned multiply) commits the 64-bit product of the zero-extended operands, split the same way as in R2.
- R4: Code 2 (signed divide) with a nonzero divisor, outside the R7 case, puts the quotient truncated toward zero in LO and the remainder in HI. The remainder carries the dividend's sign.
- R5: Code 3 (unsigned divide) with a nonzero divisor puts the quotient in LO and the remainder in HI.
- R6: A signed divide by zero sets HI to the dividend. It sets LO to 0xFFFFFFFF when the dividend is non-negative and to 1 when the dividend is negative.
- R7: A signed divide of 0x80000000 by 0xFFFFFFFF sets HI to 0 and LO to 0x80000000.
- R8: An unsigned divide by zero sets HI to the dividend and LO to 0xFFFFFFFF.
- R9: Code 4 loads HI from `opa` and code 5 loads LO from `opa`. The write takes effect at the edge that samples `start`, leaves the other register unchanged and leaves `busy` low.
- R10: After the edge that accepts an arithmetic code, `busy` stays high for exactly 33 cycles. HI and LO keep their old values throughout, and the result appears when `busy` falls.
- R11: A new arithmetic or move operation accepted while `busy` is high aborts the running one, and the aborted operation never writes HI or LO. A new arithmetic operation then takes the full 33 cycles from its own start.
- R12: Codes 6 and 7 have no effect. They do not change HI, LO or `busy`, and they do not disturb an operation that is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accept `op`, `opa` and `opb` at this edge |
| op | input | 3 | Operation code (see R2 to R9, R12) |
| opa | input | 32 | Multiplicand, dividend, or move value |
| opb | input | 32 | Multiplier or divisor |
| busy | output | 1 | An arithmetic operation is in progress |
| hi | output | 32 | HI register: product upper half or remainder |
| lo | output | 32 | LO register: product lower half or quotient |

## Verification
The bench goes after the sign corners of the datapath: the most-negative operand squared, all-ones unsigned operands, and divides where only one operand is negative. A fix-up stage that negated the remainder by the quotient's sign, or that skipped the double-width negation, would return wrong HI values in these cases. Divide by zero is run with a positive, a negative and a zero dividend, and the most-negative-over-minus-one case is run separately. A unit that took these results straight from the magnitude datapath, or that swapped the sign test, would commit an all-ones or wrongly signed LO. Abort behaviour is exercised by restarting mid-operation, by a move mid-operation and by undefined codes mid-operation. A unit that let a stale operation finish, or that treated codes 6 and 7 as a restart, would leave the wrong HI/LO values or the wrong `busy` length.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [2:0] {
        OP_MUL_S  = 3'd0,
        OP_MUL_U  = 3'd1,
        OP_DIV_S  = 3'd2,
        OP_DIV_U  = 3'd3,
        OP_SET_HI = 3'd4,
        OP_SET_LO = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FIX
    } state_e;

    // Sign and kind of the operation in flight
    typedef struct packed {
        logic is_div;
        logic is_signed;
        logic neg_a;
        logic neg_b;
    } job_t;

    function automatic logic op_is_arith(input logic [2:0] code);
        return code < 3'd4;
    endfunction

    function automatic logic op_is_move(input logic [2:0] code);
        return (code == OP_SET_HI) || (code == OP_SET_LO);
    endfunction

    function automatic logic op_is_div(input logic [2:0] code);
        return (code == OP_DIV_S) || (code == OP_DIV_U);
    endfunction

    function automatic logic op_is_signed(input logic [2:0] code);
        return (code == OP_MUL_S) || (code == OP_DIV_S);
    endfunction

endpackage

// File: rtl/muldiv_prep.sv
module muldiv_prep #(
    parameter int W = 32
) (
    input  logic         is_signed,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] mag_a,
    output logic [W-1:0] mag_b,
    output logic         neg_a,
    output logic         neg_b
);
    // Magnitudes for the unsigned iterative datapath; the most-negative
    // value maps onto its own bit pattern, which is its correct magnitude.
    always_comb begin
        neg_a = is_signed && a[W-1];
        neg_b = is_signed && b[W-1];
        mag_a = neg_a ? (~a + W'(1)) : a;
        mag_b = neg_b ? (~b + W'(1)) : b;
    end

endmodule

// File: rtl/mul_iter.sv
module mul_iter #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic           step,
    input  logic [W-1:0]   mcand,
    input  logic [W-1:0]   mplier,
    output logic [2*W-1:0] prod
);
    logic [W-1:0] mcand_q;
    logic [W:0]   upper_sum;

    // One shift-add step: add the multiplicand when the low bit is set,
    // then shift the whole product right by one.
    always_comb begin
        upper_sum = {1'b0, prod[2*W-1:W]} + (prod[0] ? {1'b0, mcand_q} : '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prod    <= '0;
            mcand_q <= '0;
        end else if (load) begin
            prod    <= {{W{1'b0}}, mplier};
            mcand_q <= mcand;
        end else if (step) begin
            prod    <= {upper_sum, prod[W-1:1]};
        end
    end

endmodule

// File: rtl/div_iter.sv
module div_iter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    logic [W-1:0] dsor_q;
    logic [W:0]   shifted;
    logic [W:0]   trial;
    logic         fits;

    // Restoring step: bring in the next dividend bit, subtract if it fits.
    always_comb begin
        shifted = {rem, quo[W-1]};
        trial   = shifted - {1'b0, dsor_q};
        fits    = shifted >= {1'b0, dsor_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            quo    <= '0;
            rem    <= '0;
            dsor_q <= '0;
        end else if (load) begin
            quo    <= dividend;
            rem    <= '0;
            dsor_q <= divisor;
        end else if (step) begin
            quo    <= {quo[W-2:0], fits};
            rem    <= fits ? trial[W-1:0] : shifted[W-1:0];
        end
    end

endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo import muldiv_pkg::*; #(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [2:0]   op,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic         busy,
    output logic [W-1:0] hi,
    output logic [W-1:0] lo
);
    localparam int            CW      = $clog2(W);
    localparam logic [CW-1:0] LAST    = CW'(W - 1);
    localparam logic [W-1:0]  MIN_NEG = {1'b1, {(W-1){1'b0}}};

    state_e          state_q;
    logic [CW-1:0]   cnt_q;
    job_t            job_q;
    logic [W-1:0]    a_raw, b_raw;
    logic [W-1:0]    hi_q, lo_q;

    logic            load, step, mov_hi, mov_lo, commit;
    logic [W-1:0]    mag_a, mag_b;
    logic            neg_a, neg_b;
    logic [2*W-1:0]  prod, prod_s;
    logic [W-1:0]    quo, rem;
    logic [W-1:0]    res_hi, res_lo;

    assign load   = start && op_is_arith(op);
    assign mov_hi = start && (op == OP_SET_HI);
    assign mov_lo = start && (op == OP_SET_LO);
    assign step   = (state_q == ST_RUN) && !load;
    assign commit = (state_q == ST_FIX) && !load && !mov_hi && !mov_lo;
    assign busy   = (state_q != ST_IDLE);
    assign hi     = hi_q;
    assign lo     = lo_q;

    muldiv_prep #(.W(W)) u_prep (
        .is_signed (op_is_signed(op)),
        .a         (opa),
        .b         (opb),
        .mag_a     (mag_a),
        .mag_b     (mag_b),
        .neg_a     (neg_a),
        .neg_b     (neg_b)
    );

    mul_iter #(.W(W)) u_mul (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .step   (step && !job_q.is_div),
        .mcand  (mag_a),
        .mplier (mag_b),
        .prod   (prod)
    );

    div_iter #(.W(W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .step     (step && job_q.is_div),
        .dividend (mag_a),
        .divisor  (mag_b),
        .quo      (quo),
        .rem      (rem)
    );

    // Sequencer: load, W iteration cycles, one fix-up/commit cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            job_q   <= '0;
            a_raw   <= '0;
            b_raw   <= '0;
        end else if (load) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
            job_q   <= '{is_div: op_is_div(op), is_signed: op_is_signed(op),
                         neg_a: neg_a, neg_b: neg_b};
            a_raw   <= opa;
            b_raw   <= opb;
        end else if (mov_hi || mov_lo) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_RUN: begin
                    cnt_q <= cnt_q + CW'(1);
                    if (cnt_q == LAST) state_q <= ST_FIX;
                end
                ST_FIX:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Sign fix-up and the fixed results of the non-faulting divide cases
    always_comb begin
        prod_s = (job_q.neg_a ^ job_q.neg_b) ? (~prod + (2*W)'(1)) : prod;
        res_hi = prod_s[2*W-1:W];
        res_lo = prod_s[W-1:0];
        if (job_q.is_div) begin
            if (b_raw == '0) begin
                res_hi = a_raw;
                res_lo = (job_q.is_signed && a_raw[W-1]) ? W'(1) : '1;
            end else if (job_q.is_signed && a_raw == MIN_NEG && b_raw == '1) begin
                res_hi = '0;
                res_lo = MIN_NEG;
            end else begin
                res_lo = (job_q.neg_a ^ job_q.neg_b) ? (~quo + W'(1)) : quo;
                res_hi = job_q.neg_a ? (~rem + W'(1)) : rem;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (mov_hi) begin
            hi_q <= opa;
        end else if (mov_lo) begin
            lo_q <= opa;
        end else if (commit) begin
            hi_q <= res_hi;
            lo_q <= res_lo;
        end
    end

    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        load |=> busy); // R10
    AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy && !start |=> !busy || ($stable(hi) && $stable(lo))); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy && !load && !mov_hi && !mov_lo |=> !busy && $stable(hi) && $stable(lo)); // R12
    AST_MOVE_HI: assert property (@(posedge clk) disable iff (rst)
        mov_hi |=> !busy && hi == $past(opa) && $stable(lo)); // R9
    AST_RESTART: assert property (@(posedge clk) disable iff (rst)
        busy && load |=> busy && cnt_q == '0); // R11
    AST_UDIV_ZERO: assert property (@(posedge clk) disable iff (rst)
        commit && job_q.is_div && !job_q.is_signed && b_raw == '0
        |=> lo == '1 && hi == $past(a_raw)); // R8
    AST_SDIV_OVF: assert property (@(posedge clk) disable iff (rst)
        commit && job_q.is_div && job_q.is_signed && a_raw == MIN_NEG && b_raw == '1
        |=> lo == MIN_NEG && hi == '0); // R7

endmodule

// File: tb/muldiv_hilo_bench.sv
module muldiv_hilo_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [31:0] opa = '0, opb = '0;
    logic        busy;
    logic [31:0] hi, lo;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #4 clk = ~clk;

    muldiv_hilo u_muldiv_hilo (
        .clk(clk), .rst(rst), .start(start), .op(op),
        .opa(opa), .opb(opb), .busy(busy), .hi(hi), .lo(lo)
    );

    localparam int NV = 15;
    // Stimulus table; expected HI/LO come from the model below.
    localparam logic [2:0] T_OP [NV] = '{
        3'd0, 3'd0, 3'd0,            // R2
        3'd1, 3'd1,                  // R3
        3'd2, 3'd2, 3'd2,            // R4
        3'd3, 3'd3,                  // R5
        3'd2, 3'd2, 3'd2,            // R6
        3'd2,                        // R7
        3'd3                         // R8
    };
    localparam logic [31:0] T_A [NV] = '{
        32'd7, 32'h80000000, 32'hFFFFFFFF,
        32'hFFFFFFFF, 32'h12345678,
        32'hFFFFFFF9, 32'd7, 32'd100,
        32'hFFFFFFFF, 32'd5,
        32'd5, 32'hFFFFFFFB, 32'd0,
        32'h80000000,
        32'h80000000
    };
    localparam logic [31:0] T_B [NV] = '{
        32'hFFFFFFFD, 32'h80000000, 32'hFFFFFFFF,
        32'hFFFFFFFF, 32'h9ABCDEF0,
        32'd2, 32'hFFFFFFFE, 32'd7,
        32'd3, 32'd9,
        32'd0, 32'd0, 32'd0,
        32'hFFFFFFFF,
        32'd0
    };

    function automatic logic [63:0] model(input logic [2:0] c, input logic [31:0] a, input logic [31:0] b);
        logic signed [63:0] sp;
        logic signed [31:0] sa, sb;
        sa = a;
        sb = b;
        case (c)
            3'd0: begin
                sp = $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b});
                return sp;
            end
            3'd1: return {32'd0, a} * {32'd0, b};
            3'd2: begin
                if (b == 32'd0) return {a, a[31] ? 32'd1 : 32'hFFFFFFFF};
                if (a == 32'h80000000 && b == 32'hFFFFFFFF) return {32'd0, 32'h80000000};
                return {32'(sa % sb), 32'(sa / sb)};
            end
            default: begin
                if (b == 32'd0) return {a, 32'hFFFFFFFF};
                return {a % b, a / b};
            end
        endcase
    endfunction

    function automatic string req_of(input logic [2:0] c, input logic [31:0] a, input logic [31:0] b);
        case (c)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: begin
                if (b == 32'd0) return "R6";
                if (a == 32'h80000000 && b == 32'hFFFFFFFF) return "R7";
                return "R4";
            end
            default: return (b == 32'd0) ? "R8" : "R5";
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge after the accepting edge.
    task automatic drive(input logic [2:0] c, input logic [31:0] a, input logic [31:0] b);
        start = 1'b1;
        op    = c;
        opa   = a;
        opb   = b;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input logic [31:0] hold_hi, input logic [31:0] hold_lo, output int n, output int moved);
        n = 0;
        moved = 0;
        while (busy && n < 100) begin
            if (hi !== hold_hi || lo !== hold_lo) moved++;
            n++;
            @(negedge clk);
        end
    endtask

    task automatic run_vec(input logic [2:0] c, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] h0, l0;
        logic [63:0] e;
        int n, moved;
        string r;
        h0 = hi;
        l0 = lo;
        e  = model(c, a, b);
        r  = req_of(c, a, b);
        drive(c, a, b);
        wait_done(h0, l0, n, moved);
        chk("R10", "busy cycles", n, 33);
        chk("R10", "HI/LO changed while busy", moved, 0);
        chk(r, "HI", hi, e[63:32]);
        chk(r, "LO", lo, e[31:0]);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_fails++;
            $display("FAIL R10 watchdog: actual no completion expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] h0, l0;
        logic [63:0] e;
        int n, moved;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "HI after reset", hi, 32'd0);
        chk("R1", "LO after reset", lo, 32'd0);
        chk("R1", "busy after reset", 32'(busy), 32'd0);

        for (int i = 0; i < NV; i++) run_vec(T_OP[i], T_A[i], T_B[i]);

        // R9 moves
        l0 = lo;
        drive(3'd4, 32'hCAFEF00D, 32'h0);
        chk("R9", "HI after move", hi, 32'hCAFEF00D);
        chk("R9", "LO untouched by HI move", lo, l0);
        chk("R9", "busy after move", 32'(busy), 32'd0);
        drive(3'd5, 32'h0BADBEEF, 32'h0);
        chk("R9", "LO after move", lo, 32'h0BADBEEF);
        chk("R9", "HI untouched by LO move", hi, 32'hCAFEF00D);

        // R12 undefined code while idle
        drive(3'd6, 32'h11111111, 32'h22222222);
        chk("R12", "HI after code 6", hi, 32'hCAFEF00D);
        chk("R12", "LO after code 6", lo, 32'h0BADBEEF);
        chk("R12", "busy after code 6", 32'(busy), 32'd0);

        // R12 undefined code while busy does not disturb the operation
        h0 = hi; l0 = lo;
        e = model(3'd1, 32'hDEADBEEF, 32'h00010001);
        drive(3'd1, 32'hDEADBEEF, 32'h00010001);
        repeat (4) @(negedge clk);
        drive(3'd7, 32'h5, 32'h6);
        chk("R12", "busy after code 7", 32'(busy), 32'd1);
        wait_done(h0, l0, n, moved);
        chk("R12", "HI after code 7 mid-op", hi, e[63:32]);
        chk("R12", "LO after code 7 mid-op", lo, e[31:0]);

        // R11 restart with a new arithmetic operation
        h0 = hi; l0 = lo;
        e = model(3'd2, 32'hFFFFFC18, 32'd7);
        drive(3'd1, 32'h12345678, 32'h87654321);
        repeat (10) @(negedge clk);
        drive(3'd2, 32'hFFFFFC18, 32'd7);
        wait_done(h0, l0, n, moved);
        chk("R11", "busy cycles after restart", n, 33);
        chk("R11", "HI/LO changed before restart result", moved, 0);
        chk("R11", "HI after restart", hi, e[63:32]);
        chk("R11", "LO after restart", lo, e[31:0]);

        // R11 move while busy aborts the operation
        h0 = hi;
        drive(3'd0, 32'h7FFFFFFF, 32'h7FFFFFFF);
        repeat (5) @(negedge clk);
        drive(3'd5, 32'h00001234, 32'h0);
        chk("R11", "busy after move abort", 32'(busy), 32'd0);
        chk("R11", "LO after move abort", lo, 32'h00001234);
        repeat (40) @(negedge clk);
        chk("R11", "HI not written by aborted op", hi, h0);
        chk("R11", "LO not written by aborted op", lo, 32'h00001234);

        // R1 reset in the middle of an operation
        drive(3'd1, 32'hFFFFFFFF, 32'h3);
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1", "HI after mid-op reset", hi, 32'd0);
        chk("R1", "LO after mid-op reset", lo, 32'd0);
        chk("R1", "busy after mid-op reset", 32'(busy), 32'd0);
        repeat (40) @(negedge clk);
        chk("R1", "HI stays zero after reset", hi, 32'd0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule